// File: doc/BRIEF.md
# Warp Resampling Address Sequencer

This block produces the address stream for geometric resampling of an image. It walks the destination image in raster order. For every destination pixel it evaluates a second-order polynomial in the destination coordinates, separately for the source X and Y axes, to obtain a fixed-point source position. It then visits every tap of the selected resampling kernel. For each tap it presents the source pixel address, the lookup address of the weight table and the strobes that steer an external multiply-accumulate unit.

A host writes the twelve polynomial coefficients, the destination size and the kernel mode through a simple write port while the block is idle. A start pulse then launches a full frame that needs no further attention. A one-cycle completion pulse ends it. The sequencer adds the same amount of work to every pixel, whatever the coefficients are, so a frame always takes `(W·H·taps)` cycles of output. This makes frame time a fixed function of the mode and the destination size.

Top module: `warp_addr_seq`

## Requirements
- R1: Write port: with `ld_we` high and the block idle, `ld_data` is stored into the register chosen by `ld_sel`. Selects 0..5 hold X coefficients c0..c5, 6..11 hold Y coefficients c0..c5, 12 holds the last destination column, 13 the last destination row, and 14 the mode in bits 1:0. Writes that arrive while `busy` is high are dropped.
- R2: `go` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance, and the first tap appears one cycle later. A `go` that arrives during a frame neither restarts nor disturbs it.
- R3: Destination pixels are visited with the column index incrementing fastest. `dst_x`/`dst_y` carry the destination column and row of the current tap.
- R4: The source position per axis is c0 + c1·u + c2·v + c3·u² + c4·u·v + c5·v², computed modulo 2^32 in signed Q16.16 (u = column, v = row). Bits 27:16 form the integer part and bits 15:12 the 4-bit fraction.
- R5: Mode 0 (and mode 3, which behaves the same) is nearest-neighbour. Each pixel has one tap, whose address is the integer part plus the fraction MSB, and output pixels follow one per clock.
- R6: Mode 1 is bilinear. There are 4 taps in the order (x,y), (x+1,y), (x,y+1), (x+1,y+1), where x and y are the integer parts.
- R7: Mode 2 is cubic. There are 16 taps in row-major order over x−1..x+2 and y−1..y+2.
- R8: `coef_addr` equals {Y fraction, X fraction}.
- R9: `acc_clr` is high on the first tap of each pixel and `acc_dump` on the last. In single-tap modes both are high on the same tap.
- R10: `frame_end` is high on the final tap of the frame, and `busy` is low from that cycle. `done` pulses for exactly one cycle on the following cycle.
- R11: Taps of a frame appear on consecutive cycles with `tap_valid` high, W·H·taps in total, independent of the coefficients.
- R12: Source addresses wrap modulo 4096 in both directions.
- R13: After reset all outputs are zero and the block is idle in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_we | input | 1 | Parameter write enable |
| ld_sel | input | 4 | Parameter register select |
| ld_data | input | 32 | Parameter write data |
| go | input | 1 | Start a frame |
| busy | output | 1 | Frame in progress |
| tap_valid | output | 1 | Tap outputs valid this cycle |
| src_x | output | 12 | Source pixel column address |
| src_y | output | 12 | Source pixel row address |
| coef_addr | output | 8 | Weight table address {Y frac, X frac} |
| acc_clr | output | 1 | First tap of a destination pixel |
| acc_dump | output | 1 | Last tap of a destination pixel |
| dst_x | output | 12 | Destination column |
| dst_y | output | 12 | Destination row |
| frame_end | output | 1 | Last tap of the frame |
| done | output | 1 | One-cycle completion pulse |

## Verification
The clear and dump strobes share one cycle whenever the kernel has a single tap. In a 1×1 frame they also coincide with `frame_end`. The bench provokes these cases with nearest-mode frames, including a single-pixel one, and compares each strobe as its own bit of the expected tap word, so a design that lets one strobe mask another shows up. A second collision, a start request and a parameter write arriving in the middle of a frame, is judged by checking that the running sequence continues unchanged. A following frame, started without reloading, must then still use the old parameters.

// File: rtl/warp_pkg.sv
`timescale 1ns/1ps
package warp_pkg;

  // Kernel selection; the fourth code aliases nearest-neighbour.
  typedef enum logic [1:0] {
    MODE_NEAREST  = 2'd0,
    MODE_BILINEAR = 2'd1,
    MODE_CUBIC    = 2'd2,
    MODE_NEAR_ALT = 2'd3
  } mode_e;

  localparam int MAX_TAPS = 16;
  localparam int TAP_W    = $clog2(MAX_TAPS);

  // Number of taps for one destination pixel.
  function automatic logic [TAP_W:0] tap_count(mode_e m);
    case (m)
      MODE_BILINEAR: return (TAP_W+1)'(4);
      MODE_CUBIC:    return (TAP_W+1)'(16);
      default:       return (TAP_W+1)'(1);
    endcase
  endfunction

  // Column offset of tap t inside the kernel window.
  function automatic logic [1:0] tap_dx(mode_e m, logic [TAP_W-1:0] t);
    case (m)
      MODE_BILINEAR: return {1'b0, t[0]};
      MODE_CUBIC:    return t[1:0];
      default:       return 2'd0;
    endcase
  endfunction

  // Row offset of tap t inside the kernel window.
  function automatic logic [1:0] tap_dy(mode_e m, logic [TAP_W-1:0] t);
    case (m)
      MODE_BILINEAR: return {1'b0, t[1]};
      MODE_CUBIC:    return t[3:2];
      default:       return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/warp_axis.sv
`timescale 1ns/1ps
// One axis of the polynomial source-position generator, advanced by
// forward differences: only additions, no multipliers.
module warp_axis #(
  parameter int ACC_W   = 32,
  parameter int ACC_FW  = 16,
  parameter int COORD_W = 12,
  parameter int SUB_W   = 4
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   init_i,
  input  logic                   col_step_i,
  input  logic                   row_step_i,
  input  logic [5:0][ACC_W-1:0]  coef_i,
  output logic [COORD_W-1:0]     int_o,
  output logic [SUB_W-1:0]       frac_o
);

  logic [ACC_W-1:0] pos_q;       // value at current pixel
  logic [ACC_W-1:0] col_d_q;     // difference to next column
  logic [ACC_W-1:0] row_q;       // value at column 0 of current row
  logic [ACC_W-1:0] row_d_q;     // difference to next row start
  logic [ACC_W-1:0] row_cd_q;    // column difference at row start

  logic [ACC_W-1:0] col_dd, row_dd, row_next, row_cd_next;

  assign col_dd      = coef_i[3] << 1;
  assign row_dd      = coef_i[5] << 1;
  assign row_next    = row_q + row_d_q;
  assign row_cd_next = row_cd_q + coef_i[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      col_d_q  <= '0;
      row_q    <= '0;
      row_d_q  <= '0;
      row_cd_q <= '0;
    end else if (init_i) begin
      pos_q    <= coef_i[0];
      row_q    <= coef_i[0];
      col_d_q  <= coef_i[1] + coef_i[3];
      row_cd_q <= coef_i[1] + coef_i[3];
      row_d_q  <= coef_i[2] + coef_i[5];
    end else if (row_step_i) begin
      pos_q    <= row_next;
      row_q    <= row_next;
      row_d_q  <= row_d_q + row_dd;
      col_d_q  <= row_cd_next;
      row_cd_q <= row_cd_next;
    end else if (col_step_i) begin
      pos_q    <= pos_q + col_d_q;
      col_d_q  <= col_d_q + col_dd;
    end
  end

  assign int_o  = pos_q[ACC_FW+COORD_W-1:ACC_FW];
  assign frac_o = pos_q[ACC_FW-1 -: SUB_W];

  // R3: the generator never receives two kinds of advance at once
  assert_single_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({init_i, col_step_i, row_step_i}));

endmodule

// File: rtl/warp_scan.sv
`timescale 1ns/1ps
// Frame scanner: tap, column and row counters plus run control.
module warp_scan import warp_pkg::*; #(
  parameter int DIM_W = 12
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  mode_e                mode_i,
  input  logic [DIM_W-1:0]     last_col_i,
  input  logic [DIM_W-1:0]     last_row_i,
  output logic                 start_ok_o,
  output logic                 run_o,
  output logic [TAP_W-1:0]     tap_o,
  output logic [DIM_W-1:0]     col_o,
  output logic [DIM_W-1:0]     row_o,
  output logic                 tap_first_o,
  output logic                 tap_last_o,
  output logic                 col_step_o,
  output logic                 row_step_o,
  output logic                 finish_o
);

  logic             run_q;
  logic [TAP_W-1:0] tap_q;
  logic [DIM_W-1:0] col_q, row_q;
  logic [TAP_W:0]   n_taps;
  logic             at_col_end, at_row_end;

  assign n_taps      = tap_count(mode_i);
  assign start_ok_o  = start_i && !run_q;
  assign tap_first_o = run_q && (tap_q == '0);
  assign tap_last_o  = run_q && ({1'b0, tap_q} == n_taps - 1'b1);
  assign at_col_end  = (col_q == last_col_i);
  assign at_row_end  = (row_q == last_row_i);
  assign col_step_o  = tap_last_o && !at_col_end;
  assign row_step_o  = tap_last_o && at_col_end && !at_row_end;
  assign finish_o    = tap_last_o && at_col_end && at_row_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      tap_q <= '0;
      col_q <= '0;
      row_q <= '0;
    end else if (start_ok_o) begin
      run_q <= 1'b1;
      tap_q <= '0;
      col_q <= '0;
      row_q <= '0;
    end else if (run_q) begin
      if (tap_last_o) begin
        tap_q <= '0;
        if (col_step_o) col_q <= col_q + 1'b1;
        if (row_step_o) begin
          col_q <= '0;
          row_q <= row_q + 1'b1;
        end
        if (finish_o) begin
          run_q <= 1'b0;
          col_q <= '0;
          row_q <= '0;
        end
      end else begin
        tap_q <= tap_q + 1'b1;
      end
    end
  end

  assign run_o = run_q;
  assign tap_o = tap_q;
  assign col_o = col_q;
  assign row_o = row_q;

  // R7: the tap counter stays inside the kernel of the current mode
  assert_tap_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ({1'b0, tap_q} < n_taps));

  // R2: a start request during a frame does not send the scan back to its origin
  assert_restart_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && start_i && !finish_o) |=> (run_q && (tap_q != '0 || col_q != '0 || row_q != '0)));

  // R3: one advance kind per cycle
  assert_step_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({col_step_o, row_step_o, finish_o}));

endmodule

// File: rtl/warp_addr_seq.sv
`timescale 1ns/1ps
module warp_addr_seq import warp_pkg::*; #(
  parameter int COORD_W = 12,
  parameter int SUB_W   = 4,
  parameter int ACC_W   = 32,
  parameter int ACC_FW  = 16,
  parameter int SEL_W   = 4
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_we,
  input  logic [SEL_W-1:0]     ld_sel,
  input  logic [ACC_W-1:0]     ld_data,
  input  logic                 go,
  output logic                 busy,
  output logic                 tap_valid,
  output logic [COORD_W-1:0]   src_x,
  output logic [COORD_W-1:0]   src_y,
  output logic [2*SUB_W-1:0]   coef_addr,
  output logic                 acc_clr,
  output logic                 acc_dump,
  output logic [COORD_W-1:0]   dst_x,
  output logic [COORD_W-1:0]   dst_y,
  output logic                 frame_end,
  output logic                 done
);

  localparam int N_AXES       = 2;
  localparam int N_COEF       = 6;
  localparam int SEL_LAST_COL = N_AXES * N_COEF;
  localparam int SEL_LAST_ROW = SEL_LAST_COL + 1;
  localparam int SEL_MODE     = SEL_LAST_COL + 2;

  // Source tap address for one axis.
  function automatic logic [COORD_W-1:0] tap_coord(logic [COORD_W-1:0] ip,
                                                   logic [SUB_W-1:0] fp,
                                                   mode_e m, logic [1:0] d);
    case (m)
      MODE_BILINEAR: return ip + COORD_W'(d);
      MODE_CUBIC:    return ip + COORD_W'(d) - COORD_W'(1);
      default:       return ip + COORD_W'(fp[SUB_W-1]);
    endcase
  endfunction

  // ---------------- parameter registers ----------------
  logic [N_AXES-1:0][N_COEF-1:0][ACC_W-1:0] coef_q;
  logic [COORD_W-1:0] last_col_q, last_row_q;
  mode_e              mode_q;
  logic               run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_q     <= '0;
      last_col_q <= '0;
      last_row_q <= '0;
      mode_q     <= MODE_NEAREST;
    end else if (ld_we && !run) begin
      for (int a = 0; a < N_AXES; a++)
        for (int k = 0; k < N_COEF; k++)
          if (ld_sel == SEL_W'(a*N_COEF + k)) coef_q[a][k] <= ld_data;
      if (ld_sel == SEL_W'(SEL_LAST_COL)) last_col_q <= ld_data[COORD_W-1:0];
      if (ld_sel == SEL_W'(SEL_LAST_ROW)) last_row_q <= ld_data[COORD_W-1:0];
      if (ld_sel == SEL_W'(SEL_MODE))     mode_q     <= mode_e'(ld_data[1:0]);
    end
  end

  // ---------------- scanner ----------------
  logic               start_ok, tap_first, tap_last, col_step, row_step, finish;
  logic [TAP_W-1:0]   tap;
  logic [COORD_W-1:0] col, row;

  warp_scan #(.DIM_W(COORD_W)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (go),
    .mode_i      (mode_q),
    .last_col_i  (last_col_q),
    .last_row_i  (last_row_q),
    .start_ok_o  (start_ok),
    .run_o       (run),
    .tap_o       (tap),
    .col_o       (col),
    .row_o       (row),
    .tap_first_o (tap_first),
    .tap_last_o  (tap_last),
    .col_step_o  (col_step),
    .row_step_o  (row_step),
    .finish_o    (finish)
  );

  // ---------------- per-axis position generators ----------------
  logic [N_AXES-1:0][COORD_W-1:0] ip;
  logic [N_AXES-1:0][SUB_W-1:0]   fp;

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    warp_axis #(
      .ACC_W(ACC_W), .ACC_FW(ACC_FW), .COORD_W(COORD_W), .SUB_W(SUB_W)
    ) u_axis (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_i     (start_ok),
      .col_step_i (col_step),
      .row_step_i (row_step),
      .coef_i     (coef_q[a]),
      .int_o      (ip[a]),
      .frac_o     (fp[a])
    );
  end

  // ---------------- registered outputs ----------------
  logic               valid_q, clr_q, dump_q, fend_q, done_q;
  logic [COORD_W-1:0] sx_q, sy_q, dx_q, dy_q;
  logic [2*SUB_W-1:0] caddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      clr_q   <= 1'b0;
      dump_q  <= 1'b0;
      fend_q  <= 1'b0;
      done_q  <= 1'b0;
      sx_q    <= '0;
      sy_q    <= '0;
      dx_q    <= '0;
      dy_q    <= '0;
      caddr_q <= '0;
    end else begin
      valid_q <= run;
      clr_q   <= tap_first;
      dump_q  <= tap_last;
      fend_q  <= finish;
      done_q  <= fend_q;
      if (run) begin
        sx_q    <= tap_coord(ip[0], fp[0], mode_q, tap_dx(mode_q, tap));
        sy_q    <= tap_coord(ip[1], fp[1], mode_q, tap_dy(mode_q, tap));
        caddr_q <= {fp[1], fp[0]};
        dx_q    <= col;
        dy_q    <= row;
      end
    end
  end

  assign busy      = run;
  assign tap_valid = valid_q;
  assign src_x     = sx_q;
  assign src_y     = sy_q;
  assign coef_addr = caddr_q;
  assign acc_clr   = clr_q;
  assign acc_dump  = dump_q;
  assign dst_x     = dx_q;
  assign dst_y     = dy_q;
  assign frame_end = fend_q;
  assign done      = done_q;

  // R1: parameter writes during a frame leave every parameter register untouched
  assert_load_blocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we && run) |=> ($stable(coef_q) && $stable(mode_q) &&
                        $stable(last_col_q) && $stable(last_row_q)));

  // R9: strobes only appear on valid taps
  assert_strobe_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clr || acc_dump || frame_end) |-> tap_valid);

  // R5: single-tap kernels clear and dump on the same tap
  assert_nearest_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_valid && (mode_q == MODE_NEAREST || mode_q == MODE_NEAR_ALT)) |-> (acc_clr && acc_dump));

  // R10: done follows frame_end by one cycle, lasts one cycle, and the block is idle
  assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (done && !tap_valid));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !busy);

endmodule

// File: tb/test_warp_addr_seq.sv
`timescale 1ns/1ps
module test_warp_addr_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_we = 1'b0;
  logic [3:0]  ld_sel = '0;
  logic [31:0] ld_data = '0;
  logic        go = 1'b0;
  logic        busy, tap_valid, acc_clr, acc_dump, frame_end, done;
  logic [11:0] src_x, src_y, dst_x, dst_y;
  logic [7:0]  coef_addr;

  always #2.5 clk = ~clk;

  warp_addr_seq i_warp_addr_seq (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_sel(ld_sel), .ld_data(ld_data),
    .go(go), .busy(busy), .tap_valid(tap_valid), .src_x(src_x), .src_y(src_y),
    .coef_addr(coef_addr), .acc_clr(acc_clr), .acc_dump(acc_dump),
    .dst_x(dst_x), .dst_y(dst_y), .frame_end(frame_end), .done(done)
  );

  int tests = 0;
  int fails = 0;

  // model of the programmed parameters
  int mc[2][6];
  int mlc, mlr, mmode;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    ld_sel = 4'(sel); ld_data = d; ld_we = 1'b1;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic load_model();
    for (int a = 0; a < 2; a++)
      for (int k = 0; k < 6; k++) wr(a*6 + k, mc[a][k]);
    wr(12, mlc); wr(13, mlr); wr(14, mmode);
  endtask

  function automatic logic [31:0] poly(int a, int u, int v);
    longint s;
    s = longint'(mc[a][0]) + longint'(mc[a][1])*u + longint'(mc[a][2])*v
      + longint'(mc[a][3])*u*u + longint'(mc[a][4])*u*v + longint'(mc[a][5])*v*v;
    return s[31:0];
  endfunction

  function automatic int ntaps(int m);
    return (m == 1) ? 4 : (m == 2) ? 16 : 1;
  endfunction

  function automatic int kdim(int m);
    return (m == 1) ? 2 : (m == 2) ? 4 : 1;
  endfunction

  function automatic int coord(logic [31:0] p, int m, int d);
    int ipart, fpart;
    ipart = int'(p[27:16]);
    fpart = int'(p[15:12]);
    if (m == 1) return (ipart + d) % 4096;
    if (m == 2) return (ipart + d + 4095) % 4096;
    return (ipart + ((fpart >= 8) ? 1 : 0)) % 4096;
  endfunction

  function automatic string mode_req(int m);
    return (m == 1) ? "R6" : (m == 2) ? "R7" : "R5";
  endfunction

  // Runs one frame from the model; poke_at >= 0 drives go and a write mid-frame.
  task automatic run_frame(input string tag, input int poke_at);
    int total, nt, dm;
    logic [63:0] act, exp;
    nt = ntaps(mmode);
    dm = kdim(mmode);
    total = (mlc + 1) * (mlr + 1) * nt;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    check(busy == 1'b1 && tap_valid == 1'b0, "R2", {tag, " busy after start"},
          {62'd0, busy, tap_valid}, 64'd2);
    for (int k = 0; k < total; k++) begin
      int t, pix, u, v;
      logic [31:0] px, py;
      @(negedge clk);
      t = k % nt; pix = k / nt;
      u = pix % (mlc + 1); v = pix / (mlc + 1);
      px = poly(0, u, v); py = poly(1, u, v);
      exp = {4'd0, 1'b1,
             12'(coord(px, mmode, t % dm)), 12'(coord(py, mmode, t / dm)),
             py[15:12], px[15:12],
             (t == 0), (t == nt - 1),
             12'(u), 12'(v), (k == total - 1)};
      act = {4'd0, tap_valid, src_x, src_y, coef_addr, acc_clr, acc_dump,
             dst_x, dst_y, frame_end};
      // R3 raster order, R4 position, R8 weight address, R9 strobes, R11 contiguity
      check(act == exp, mode_req(mmode),
            $sformatf("%s R3/R4/R8/R9/R11 tap %0d", tag, k), act, exp);
      if (k == poke_at) begin
        go = 1'b1; ld_we = 1'b1; ld_sel = 4'd14; ld_data = 32'h0000_0002;
      end else if (k == poke_at + 1) begin
        go = 1'b0; ld_we = 1'b0;
      end
    end
    @(negedge clk);
    check({tap_valid, done, busy} == 3'b010, "R10", {tag, " done after last tap"},
          {61'd0, tap_valid, done, busy}, 64'd2);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R10", {tag, " done single cycle"},
          {62'd0, done, busy}, 64'd0);
  endtask

  task automatic clear_model();
    for (int a = 0; a < 2; a++)
      for (int k = 0; k < 6; k++) mc[a][k] = 0;
  endtask

  initial begin
    #(200000 * 5);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13: reset state
    check({busy, tap_valid, done, acc_clr, acc_dump, frame_end} == 6'd0, "R13",
          "reset strobes", {58'd0, busy, tap_valid, done, acc_clr, acc_dump, frame_end}, 64'd0);
    check({src_x, src_y, coef_addr, dst_x, dst_y} == 56'd0, "R13", "reset addresses",
          {8'd0, src_x, src_y, coef_addr, dst_x, dst_y}, 64'd0);

    // R5: identity map, nearest, 4x3
    clear_model();
    mc[0][1] = 32'h0001_0000; mc[1][2] = 32'h0001_0000;
    mlc = 3; mlr = 2; mmode = 0;
    load_model();
    run_frame("identity nearest", -1);

    // R5: mode 3 behaves as nearest, fractional offset with rounding
    mc[0][0] = 32'h0002_9000; mc[1][0] = 32'h0004_7000;
    mmode = 3;
    load_model();
    run_frame("mode3 alias", -1);

    // R6: transposing map, bilinear
    clear_model();
    mc[0][0] = 32'h0005_4000; mc[0][2] = 32'h0001_0000;
    mc[1][0] = 32'h0007_9000; mc[1][1] = 32'h0001_0000;
    mlc = 2; mlr = 2; mmode = 1;
    load_model();
    run_frame("transpose bilinear", -1);

    // R7 R12: cubic window wraps below zero and past 4095
    clear_model();
    mc[0][1] = 32'h0000_8000;
    mc[1][0] = 32'h0FFF_0000; mc[1][2] = 32'h0001_0000;
    mlc = 2; mlr = 1; mmode = 2;
    load_model();
    run_frame("R12 cubic wrap", -1);

    // R12: nearest rounding carries past 4095 back to 0
    clear_model();
    mc[0][0] = 32'h0FFF_C000; mc[1][0] = 32'h0FFF_8000;
    mlc = 1; mlr = 0; mmode = 0;
    load_model();
    run_frame("R12 round wrap", -1);

    // R9 R10: single-pixel nearest frame, clear/dump/end on one tap
    mlc = 0; mlr = 0;
    load_model();
    run_frame("single pixel", -1);

    // R1 R2: start and write mid-frame are ignored, then rerun without reload
    clear_model();
    mc[0][0] = 32'h0010_3000; mc[0][1] = 32'h0000_C000; mc[0][3] = 32'h0000_0100;
    mc[1][0] = 32'h0020_D000; mc[1][2] = 32'h0001_4000; mc[1][4] = 32'hFFFF_FE00;
    mlc = 3; mlr = 2; mmode = 1;
    load_model();
    run_frame("R1 R2 poked", 5);
    run_frame("R1 kept params", -1);

    // R4 R11: random quadratic warps in every mode
    for (int i = 0; i < 8; i++) begin
      mmode = int'($urandom_range(0, 3));
      mlc = int'($urandom_range(0, 4));
      mlr = int'($urandom_range(0, 3));
      for (int a = 0; a < 2; a++) begin
        mc[a][0] = int'($urandom);
        mc[a][1] = int'($urandom_range(0, 262143)) - 131072;
        mc[a][2] = int'($urandom_range(0, 262143)) - 131072;
        for (int k = 3; k < 6; k++) mc[a][k] = int'($urandom_range(0, 1023)) - 512;
      end
      load_model();
      run_frame($sformatf("R4 random %0d", i), -1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule